// File: doc/BRIEF.md
# Changeover-Switch Debouncer with Event Counter

This block cleans up the two contact signals of a double-throw switch. It drives a stable level and counts how many times the switch is thrown to the up position. Each contact input is active low. A contact that has closed pulls its line low, and an open contact floats high through an external pull-up.

A two-state machine holds the switch position. The position moves only when the opposite contact closes. Bounce on the contact the switch is leaving therefore only opens and closes that same contact, and it cannot move the state. No settling timer is used, so a real throw takes effect as soon as it has passed through the synchronizer. When both contacts read closed at once, which happens with a make-before-break switch, the up position wins. This matches a pair of cross-coupled NAND gates.

Each rising edge of the debounced level produces a one-cycle pulse and adds one to a binary counter. The counter wraps around when it passes its largest value.

States and transitions:
- State `ST_DOWN` drives the level low. State `ST_UP` drives it high.
- Transition `T_GO_UP` is taken when the up contact reads closed, including the case where both contacts read closed.
- Transition `T_GO_DOWN` is taken when the down contact alone reads closed.
- Transition `T_HOLD` is taken when both contacts read open.

Top module: `dt_debounce_counter`

## Requirements
- R1: Both contact inputs are active low: 0 means closed and 1 means open. After reset, each synchronizer reads open.
- R2: If the up contact alone is closed, `level` is 1 from the third rising clock edge after the input changes. The first two edges pass through the synchronizer and the third updates the state.
- R3: If the down contact alone is closed, `level` is 0 with the same three-edge latency.
- R4: While both contacts read open, `level` keeps its previous value for any length of time.
- R5: While both contacts read closed, `level` is forced to 1, whatever the previous state.
- R6: No debounce interval is applied. A closure of the opposite contact reverses `level` with the same three-edge latency, even right after the previous throw.
- R7: A synchronous reset (`rst` = 1) sets `level` to 0, `count` to 0 and `count_pulse` to 0.
- R8: Each 0-to-1 change of `level` adds one to `count` and raises `count_pulse` for exactly one cycle. Both happen on the clock edge after the edge on which `level` rose. A 1-to-0 change of `level` counts nothing.
- R9: Any burst of bounce on a single contact, with the other contact open, changes `level` at most once per throw. It adds at most one count, and only for a throw to up.
- R10: `count` is COUNT_W bits wide and wraps from its largest value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_contact_n | input | 1 | Raw up-throw contact, active low |
| dn_contact_n | input | 1 | Raw down-throw contact, active low |
| level | output | 1 | Debounced switch position (1 = up) |
| count | output | COUNT_W | Number of throws to up, modulo 2^COUNT_W |
| count_pulse | output | 1 | One-cycle pulse on each counted throw |

## Verification
The bench builds the block with COUNT_W = 4 and the default two synchronizer stages. The narrow counter makes wrap-around reachable after sixteen throws, and the rest of the behaviour is the same as at full width. The fixed two-stage synchronizer makes the three-edge latency exact. This lets the bench probe the state one edge before and one edge after it moves, and catch the count pulse in its single cycle.

// File: rtl/dtdb_pkg.sv
package dtdb_pkg;
    typedef enum logic [0:0] {
        ST_DOWN = 1'b0,
        ST_UP   = 1'b1
    } sw_state_t;

    typedef enum logic [1:0] {
        T_HOLD    = 2'd0,
        T_GO_UP   = 2'd1,
        T_GO_DOWN = 2'd2
    } sw_trans_t;
endpackage

// File: rtl/dtdb_sync.sv
module dtdb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din_n,
    output logic closed
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b1;
                else if (g == 0) chain[g] <= din_n;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign closed = ~chain[STAGES-1];
endmodule

// File: rtl/dtdb_latch_fsm.sv
module dtdb_latch_fsm
    import dtdb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic up_closed,
    input  logic dn_closed,
    output logic level
);
    sw_state_t state_q, state_d;
    sw_trans_t trans;

    always_comb begin
        if (up_closed)      trans = T_GO_UP;
        else if (dn_closed) trans = T_GO_DOWN;
        else                trans = T_HOLD;
    end

    always_comb begin
        state_d = state_q;
        unique case (trans)
            T_GO_UP:   state_d = ST_UP;
            T_GO_DOWN: state_d = ST_DOWN;
            T_HOLD:    state_d = state_q;
            default:   state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_DOWN;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_UP:   level = 1'b1;
            ST_DOWN: level = 1'b0;
            default: level = 1'b0;
        endcase
    end
endmodule

// File: rtl/dtdb_edge_counter.sv
module dtdb_edge_counter #(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               level,
    output logic [COUNT_W-1:0] count,
    output logic               pulse
);
    logic level_d;
    logic rise;

    assign rise = level & ~level_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_d <= 1'b0;
            pulse   <= 1'b0;
            count   <= '0;
        end else begin
            level_d <= level;
            pulse   <= rise;
            if (rise) count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/dt_debounce_counter.sv
module dt_debounce_counter #(
    parameter int COUNT_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               up_contact_n,
    input  logic               dn_contact_n,
    output logic               level,
    output logic [COUNT_W-1:0] count,
    output logic               count_pulse
);
    logic up_closed;
    logic dn_closed;

    dtdb_sync #(.STAGES(SYNC_STAGES)) u_sync_up (
        .clk(clk), .rst(rst), .din_n(up_contact_n), .closed(up_closed)
    );

    dtdb_sync #(.STAGES(SYNC_STAGES)) u_sync_dn (
        .clk(clk), .rst(rst), .din_n(dn_contact_n), .closed(dn_closed)
    );

    dtdb_latch_fsm u_fsm (
        .clk(clk), .rst(rst),
        .up_closed(up_closed), .dn_closed(dn_closed),
        .level(level)
    );

    dtdb_edge_counter #(.COUNT_W(COUNT_W)) u_cnt (
        .clk(clk), .rst(rst), .level(level),
        .count(count), .pulse(count_pulse)
    );
endmodule

// File: rtl/dtdb_checker.sv
module dtdb_checker #(
    parameter int COUNT_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               up_closed,
    input logic               dn_closed,
    input logic               level,
    input logic [COUNT_W-1:0] count,
    input logic               count_pulse
);
    assert_up_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (up_closed && !dn_closed) |=> level);

    assert_dn_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (dn_closed && !up_closed) |=> !level);

    assert_open_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (!up_closed && !dn_closed) |=> $stable(level));

    assert_both_high_R5: assert property (@(posedge clk) disable iff (rst)
        (up_closed && dn_closed) |=> level);

    assert_pulse_after_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(level) |=> count_pulse);

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
        count_pulse |=> !count_pulse);

    assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
        count_pulse |-> (count == COUNT_W'($past(count) + 1'b1)));

    assert_count_still_R9: assert property (@(posedge clk) disable iff (rst)
        !count_pulse |-> (count == $past(count)));
endmodule

bind dt_debounce_counter dtdb_checker #(.COUNT_W(COUNT_W)) u_chk (
    .clk(clk), .rst(rst),
    .up_closed(up_closed), .dn_closed(dn_closed),
    .level(level), .count(count), .count_pulse(count_pulse)
);

// File: tb/dt_debounce_counter_tb_top.sv
`timescale 1ns/1ps
module dt_debounce_counter_tb_top;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic up_n = 1'b1;
    logic dn_n = 1'b1;
    logic level;
    logic [CW-1:0] count;
    logic count_pulse;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    logic [CW-1:0] exp_cnt = '0;

    always #2 clk = ~clk;

    dt_debounce_counter #(.COUNT_W(CW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst),
        .up_contact_n(up_n), .dn_contact_n(dn_n),
        .level(level), .count(count), .count_pulse(count_pulse)
    );

    always @(negedge clk) if (!rst && count_pulse) pulses++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic bounce(input bit on_up);
        int n = 3 + ($urandom % 6);
        for (int i = 0; i < n; i++) begin
            if (on_up) up_n = $urandom % 2; else dn_n = $urandom % 2;
            repeat (1 + ($urandom % 3)) @(negedge clk);
        end
    endtask

    task automatic throw_up(input string req);
        int p0 = pulses;
        dn_n = 1'b1;
        repeat (2) @(negedge clk);
        bounce(1'b1);
        up_n = 1'b0;
        settle();
        exp_cnt = exp_cnt + 1'b1;
        chk({req, " level up"}, level, 1);
        chk({req, " count"}, count, exp_cnt);
        chk({req, " pulses"}, pulses - p0, 1);
    endtask

    task automatic throw_down(input string req);
        int p0 = pulses;
        up_n = 1'b1;
        repeat (2) @(negedge clk);
        bounce(1'b0);
        dn_n = 1'b0;
        settle();
        chk({req, " level down"}, level, 0);
        chk({req, " count"}, count, exp_cnt);
        chk({req, " pulses"}, pulses - p0, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 level", level, 0);
        chk("R7 count", count, 0);
        chk("R7 pulse", count_pulse, 0);
        rst = 1'b0;
        settle();
        chk("R1 open after reset level", level, 0);
    endtask

    task automatic t_bounce_throws();
        for (int k = 0; k < 3; k++) begin
            throw_up("R2 R9");
            throw_down("R3 R9");
        end
    endtask

    task automatic t_hold();
        up_n = 1'b1; dn_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R4 hold low", level, 0);
        throw_up("R2");
        up_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R4 hold high", level, 1);
        bounce(1'b1);
        up_n = 1'b1;
        settle();
        chk("R9 re-bounce level", level, 1);
        chk("R9 re-bounce count", count, exp_cnt);
        throw_down("R3");
    endtask

    task automatic t_both_closed();
        int p0 = pulses;
        up_n = 1'b0; dn_n = 1'b0;
        settle();
        exp_cnt = exp_cnt + 1'b1;
        chk("R5 forced high from low", level, 1);
        chk("R5 count", count, exp_cnt);
        chk("R5 pulses", pulses - p0, 1);
        up_n = 1'b1;
        settle();
        chk("R3 down after both", level, 0);
        up_n = 1'b0; dn_n = 1'b1;
        settle();
        exp_cnt = exp_cnt + 1'b1;
        p0 = pulses;
        dn_n = 1'b0;
        settle();
        chk("R5 stays high", level, 1);
        chk("R5 no extra count", pulses - p0, 0);
        up_n = 1'b1;
        settle();
        chk("R5 then down", level, 0);
        chk("R8 count after both", count, exp_cnt);
    endtask

    task automatic t_latency();
        up_n = 1'b0; dn_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 not yet at edge 2", level, 0);
        @(negedge clk);
        chk("R2 up at edge 3", level, 1);
        chk("R8 no pulse same edge", count_pulse, 0);
        up_n = 1'b1; dn_n = 1'b0;
        @(negedge clk);
        exp_cnt = exp_cnt + 1'b1;
        chk("R8 pulse next edge", count_pulse, 1);
        chk("R8 count next edge", count, exp_cnt);
        @(negedge clk);
        chk("R8 pulse one cycle", count_pulse, 0);
        chk("R6 still up", level, 1);
        @(negedge clk);
        chk("R6 down at edge 3", level, 0);
        settle();
        chk("R8 no count on fall", count, exp_cnt);
    endtask

    task automatic t_wrap();
        int need = (1 << CW) - int'(exp_cnt);
        for (int k = 0; k < need; k++) begin
            throw_up("R10");
            throw_down("R10");
        end
        chk("R10 wrapped to zero", count, 0);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_bounce_throws();
        t_hold();
        t_both_closed();
        t_latency();
        t_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule